// File: doc/BRIEF.md
# Multi-mode configurable cell register

This block is one storage bit whose behaviour is fixed by static configuration inputs. It can store as an edge-triggered D, T, JK or SR flip-flop, or it can work as a level-sensitive latch that is transparent while its clock is high. The bit it stores comes from one of three places: the result of the preceding logic stage, a separate product term, or the pad input.

The clock is either one of the global clocks or a clock built from a product term. When a global clock drives the cell, a product-term clock enable can be switched on. While that enable is low, clock edges do nothing. An asynchronous clear and an asynchronous set act at any time. The clear can come from the global clear, from a product term, from either of them, or from nothing. The set comes from a product term or from nothing. When both are active, the clear wins.

The configuration inputs are meant to be held constant while the cell runs. They may change only while every clock input is low.

Top module: `cellreg_top`

## Requirements
- R1: With cfg_mode 0, and also with the unused codes 5, 6 and 7, each rising edge of the selected clock stores the selected data bit (D operation).
- R2: cfg_dsrc picks the data bit: 0 takes xor_in, 1 takes pt_data, and 2 or 3 takes pin_in.
- R3: With cfg_mode 1 (T), a rising edge inverts q when the data bit is 1 and leaves q unchanged when it is 0.
- R4: With cfg_mode 2 (JK), J is the selected data bit and K is pt_data. On a rising edge, J=K=0 holds q, J=1 K=0 sets it, J=0 K=1 clears it, and J=K=1 inverts it.
- R5: With cfg_mode 3 (SR), S is the selected data bit and R is pt_data. On a rising edge, S alone sets q, R alone clears it, and S=R=0 or S=R=1 holds it.
- R6: With cfg_mode 4 (latch), q follows the data bit while the selected clock is high and holds its value while the clock is low.
- R7: cfg_csrc picks the clock: values 0 to 2 take gclk[0] to gclk[2], and 3 takes pt_clk. Edges on the clocks that are not selected have no effect on q.
- R8: When cfg_ce_en is 1 and a global clock is selected, a low pt_ce makes the cell ignore clock edges and keeps the latch closed. When pt_clk is selected, pt_ce has no effect.
- R9: cfg_rsrc picks the clear: 0 none, 1 gclear, 2 pt_reset, 3 either of them. The selected clear drives q low at once, without a clock edge. A clear that is not selected has no effect.
- R10: With cfg_psrc 1, pt_preset drives q high at once, without a clock edge. With cfg_psrc 0, pt_preset has no effect.
- R11: When the selected clear and the selected preset are active together, q is low, in both flip-flop and latch modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | N_GCLK | Global clocks |
| pt_clk | input | 1 | Clock formed from a product term |
| pt_ce | input | 1 | Clock enable product term |
| gclear | input | 1 | Global asynchronous clear |
| pt_reset | input | 1 | Product-term asynchronous clear |
| pt_preset | input | 1 | Product-term asynchronous set |
| xor_in | input | 1 | Data from the logic stage |
| pt_data | input | 1 | Separate product term; also K or R input |
| pin_in | input | 1 | Data from the pad |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_dsrc | input | 2 | Data source select |
| cfg_csrc | input | CSRC_W | Clock source select |
| cfg_ce_en | input | 1 | Turns on the clock enable for global clocks |
| cfg_rsrc | input | 2 | Clear source select |
| cfg_psrc | input | 1 | Turns on the product-term preset |
| q | output | 1 | Stored value |

## Verification
The checker runs on every cycle. After each rising edge of the selected clock it compares the flip-flop with the rule for the recorded mode: D, T, JK or SR. It checks that the flip-flop holds its value on an edge that the enable blocks. It also checks that the latch equals its data when it closes, and that an active clear or preset forces the output.

Some behaviours can only be shown by the bench's scenarios. These are that unselected clocks and unselected clear or preset inputs do nothing, that the data-source and clock-source codes map to the right inputs, and that the enable is ignored when the product-term clock is selected.

// File: rtl/cellreg_pkg.sv
`timescale 1ns/1ps
package cellreg_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    DSRC_LOGIC = 2'd0,
    DSRC_TERM  = 2'd1,
    DSRC_PAD   = 2'd2,
    DSRC_PAD2  = 2'd3
  } dsrc_e;

  // Clear source: bit 0 enables the global clear, bit 1 the product term
  typedef enum logic [1:0] {
    RSRC_OFF    = 2'd0,
    RSRC_GLOBAL = 2'd1,
    RSRC_TERM   = 2'd2,
    RSRC_EITHER = 2'd3
  } rsrc_e;

  function automatic logic pick_data(input logic [1:0] src, input logic from_logic,
                                     input logic from_term, input logic from_pad);
    case (src)
      DSRC_LOGIC: return from_logic;
      DSRC_TERM:  return from_term;
      default:    return from_pad;
    endcase
  endfunction

  // Next flip-flop state; a is D/T/J/S, b is K/R
  function automatic logic next_state(input logic [2:0] mode, input logic cur,
                                      input logic a, input logic b);
    logic res;
    case (mode)
      MODE_T:  res = cur ^ a;
      MODE_JK: res = (a & ~cur) | (~b & cur);
      MODE_SR: begin
        if (a & ~b)      res = 1'b1;
        else if (b & ~a) res = 1'b0;
        else             res = cur;
      end
      default: res = a;
    endcase
    return res;
  endfunction

  function automatic logic clear_req(input logic [1:0] src, input logic glob, input logic term);
    return (src[0] & glob) | (src[1] & term);
  endfunction

endpackage

// File: rtl/cellreg_ctl.sv
`timescale 1ns/1ps
module cellreg_ctl #(
  parameter int N_GCLK = 3,
  parameter int CSRC_W = 2
) (
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic [CSRC_W-1:0] csrc,
  input  logic              ce_en,
  input  logic              pt_ce,
  input  logic              gclear,
  input  logic              pt_reset,
  input  logic              pt_preset,
  input  logic [1:0]        rsrc,
  input  logic              psrc,
  output logic              cell_clk,
  output logic              is_global,
  output logic              cap_ok,
  output logic              clr_any,
  output logic              pre_any
);
  logic [N_GCLK-1:0] hit;

  for (genvar i = 0; i < N_GCLK; i++) begin : g_hit
    assign hit[i] = (csrc == CSRC_W'(i));
  end

  assign is_global = |hit;
  assign cell_clk  = is_global ? |(hit & gclk) : pt_clk;

  // The enable only qualifies edges of a global clock
  assign cap_ok  = !(ce_en && is_global) || pt_ce;

  assign clr_any = cellreg_pkg::clear_req(rsrc, gclear, pt_reset);
  assign pre_any = psrc & pt_preset;
endmodule

// File: rtl/cellreg_dsel.sv
`timescale 1ns/1ps
module cellreg_dsel (
  input  logic [1:0] dsrc,
  input  logic       xor_in,
  input  logic       pt_data,
  input  logic       pin_in,
  output logic       d_a,
  output logic       d_b
);
  assign d_a = cellreg_pkg::pick_data(dsrc, xor_in, pt_data, pin_in);
  assign d_b = pt_data;
endmodule

// File: rtl/cellreg_core.sv
`timescale 1ns/1ps
module cellreg_core (
  input  logic       cell_clk,
  input  logic       cap_ok,
  input  logic       clr_any,
  input  logic       pre_any,
  input  logic [2:0] mode,
  input  logic       d_a,
  input  logic       d_b,
  output logic       ff_q,
  output logic       lat_q,
  output logic       q
);
  logic nxt;
  logic lat_open;

  assign nxt      = cellreg_pkg::next_state(mode, ff_q, d_a, d_b);
  assign lat_open = cell_clk & cap_ok;

  always_ff @(posedge cell_clk or posedge clr_any or posedge pre_any) begin
    if (clr_any)      ff_q <= 1'b0;
    else if (pre_any) ff_q <= 1'b1;
    else if (cap_ok)  ff_q <= nxt;
  end

  always_latch begin
    if (clr_any)       lat_q <= 1'b0;
    else if (pre_any)  lat_q <= 1'b1;
    else if (lat_open) lat_q <= d_a;
  end

  assign q = (mode == cellreg_pkg::MODE_LATCH) ? lat_q : ff_q;
endmodule

// File: rtl/cellreg_top.sv
`timescale 1ns/1ps
module cellreg_top #(
  parameter int N_GCLK = 3,
  localparam int CSRC_W = $clog2(N_GCLK + 1)
) (
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic              pt_ce,
  input  logic              gclear,
  input  logic              pt_reset,
  input  logic              pt_preset,
  input  logic              xor_in,
  input  logic              pt_data,
  input  logic              pin_in,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_dsrc,
  input  logic [CSRC_W-1:0] cfg_csrc,
  input  logic              cfg_ce_en,
  input  logic [1:0]        cfg_rsrc,
  input  logic              cfg_psrc,
  output logic              q
);
  logic cell_clk;
  logic is_global;
  logic cap_ok;
  logic clr_any;
  logic pre_any;
  logic d_a;
  logic d_b;
  logic ff_q;
  logic lat_q;

  cellreg_ctl #(.N_GCLK(N_GCLK), .CSRC_W(CSRC_W)) u_ctl (
    .gclk(gclk), .pt_clk(pt_clk), .csrc(cfg_csrc), .ce_en(cfg_ce_en), .pt_ce(pt_ce),
    .gclear(gclear), .pt_reset(pt_reset), .pt_preset(pt_preset),
    .rsrc(cfg_rsrc), .psrc(cfg_psrc),
    .cell_clk(cell_clk), .is_global(is_global), .cap_ok(cap_ok),
    .clr_any(clr_any), .pre_any(pre_any)
  );

  cellreg_dsel u_dsel (
    .dsrc(cfg_dsrc), .xor_in(xor_in), .pt_data(pt_data), .pin_in(pin_in),
    .d_a(d_a), .d_b(d_b)
  );

  cellreg_core u_core (
    .cell_clk(cell_clk), .cap_ok(cap_ok), .clr_any(clr_any), .pre_any(pre_any),
    .mode(cfg_mode), .d_a(d_a), .d_b(d_b),
    .ff_q(ff_q), .lat_q(lat_q), .q(q)
  );
endmodule

// File: rtl/cellreg_chk.sv
`timescale 1ns/1ps
module cellreg_chk (
  input logic       smp_clk,
  input logic       cell_clk,
  input logic       cap_ok,
  input logic       clr_any,
  input logic       pre_any,
  input logic [2:0] mode,
  input logic       d_a,
  input logic       d_b,
  input logic       ff_q,
  input logic       lat_q,
  input logic       q
);
  logic       async_any;
  logic       rec_valid;
  logic       rec_cap;
  logic [2:0] rec_mode;
  logic       rec_a;
  logic       rec_b;
  logic       rec_q;
  logic       rec_d;

  assign async_any = clr_any | pre_any;
  assign rec_d     = (rec_mode == 3'd0) || (rec_mode > 3'd4);

  // Capture the conditions at each active edge; an async event voids the record
  always_ff @(posedge cell_clk or posedge async_any) begin
    if (async_any) begin
      rec_valid <= 1'b0;
      rec_cap   <= 1'b0;
      rec_mode  <= 3'd0;
      rec_a     <= 1'b0;
      rec_b     <= 1'b0;
      rec_q     <= 1'b0;
    end else begin
      rec_valid <= 1'b1;
      rec_cap   <= cap_ok;
      rec_mode  <= mode;
      rec_a     <= d_a;
      rec_b     <= d_b;
      rec_q     <= ff_q;
    end
  end

  a_r1_d_stores: assert property (@(negedge cell_clk) disable iff (async_any)
    (rec_valid && rec_cap && rec_d) |-> (ff_q == rec_a));

  a_r3_t_toggles: assert property (@(negedge cell_clk) disable iff (async_any)
    (rec_valid && rec_cap && rec_mode == 3'd1) |-> (ff_q == (rec_q ^ rec_a)));

  a_r4_jk_rule: assert property (@(negedge cell_clk) disable iff (async_any)
    (rec_valid && rec_cap && rec_mode == 3'd2) |->
      (ff_q == ((rec_a && rec_b) ? !rec_q : (rec_a ? 1'b1 : (rec_b ? 1'b0 : rec_q)))));

  a_r5_sr_rule: assert property (@(negedge cell_clk) disable iff (async_any)
    (rec_valid && rec_cap && rec_mode == 3'd3) |->
      (ff_q == ((rec_a == rec_b) ? rec_q : rec_a)));

  a_r8_blocked_edge_holds: assert property (@(negedge cell_clk) disable iff (async_any)
    (rec_valid && !rec_cap) |-> (ff_q == rec_q));

  a_r6_latch_closes_on_data: assert property (@(negedge cell_clk) disable iff (async_any)
    (mode == 3'd4 && cap_ok) |-> (lat_q == d_a));

  always @(posedge smp_clk) begin
    if (clr_any) begin
      a_r9_clear_forces_low: assert (q == 1'b0);
    end
    if (pre_any && !clr_any) begin
      a_r10_preset_forces_high: assert (q == 1'b1);
    end
    if (clr_any && pre_any) begin
      a_r11_clear_beats_preset: assert (ff_q == 1'b0 && lat_q == 1'b0);
    end
  end
endmodule

bind cellreg_top cellreg_chk u_chk (
  .smp_clk(gclk[0]), .cell_clk(cell_clk), .cap_ok(cap_ok), .clr_any(clr_any),
  .pre_any(pre_any), .mode(cfg_mode), .d_a(d_a), .d_b(d_b),
  .ff_q(ff_q), .lat_q(lat_q), .q(q)
);

// File: tb/cellreg_top_bench.sv
`timescale 1ns/1ps
module cellreg_top_bench;
  logic       clk = 1'b0;
  logic       g1 = 1'b0;
  logic       g2 = 1'b0;
  logic       pt_clk = 1'b0;
  logic       pt_ce = 1'b0;
  logic       gclear = 1'b1;
  logic       pt_reset = 1'b0;
  logic       pt_preset = 1'b0;
  logic       xor_in = 1'b0;
  logic       pt_data = 1'b0;
  logic       pin_in = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_dsrc = 2'd0;
  logic [1:0] cfg_csrc = 2'd0;
  logic       cfg_ce_en = 1'b0;
  logic [1:0] cfg_rsrc = 2'd1;
  logic       cfg_psrc = 1'b0;
  logic       q;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  cellreg_top u_cellreg_top (
    .gclk({g2, g1, clk}), .pt_clk(pt_clk), .pt_ce(pt_ce), .gclear(gclear),
    .pt_reset(pt_reset), .pt_preset(pt_preset), .xor_in(xor_in), .pt_data(pt_data),
    .pin_in(pin_in), .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc), .cfg_csrc(cfg_csrc),
    .cfg_ce_en(cfg_ce_en), .cfg_rsrc(cfg_rsrc), .cfg_psrc(cfg_psrc), .q(q)
  );

  // {mode[2:0], dsrc[1:0], xor_in, pt_data, pin_in, expected q}, applied from q=0 on gclk[0]
  localparam int NV = 20;
  localparam logic [8:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tag_of(input logic [2:0] m, input logic [1:0] s);
    if (s != 2'd0) return "R2";
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic exp, input string req, input string what);
    n_chk++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s %s: q=%b expected %b", req, what, q, exp);
    end
  endtask

  task automatic pulse_g1();
    #0.5 g1 = 1'b1;
    #0.5 g1 = 1'b0;
    #0.5;
  endtask

  task automatic pulse_g2();
    #0.5 g2 = 1'b1;
    #0.5 g2 = 1'b0;
    #0.5;
  endtask

  task automatic pulse_pt();
    #0.5 pt_clk = 1'b1;
    #0.5 pt_clk = 1'b0;
    #0.5;
  endtask

  task automatic edge0();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: q=%b expected completion", q);
      summary();
    end
  end

  initial begin
    // Reset state via global clear (R9)
    @(negedge clk);
    @(negedge clk);
    chk(1'b0, "R9", "global clear at start");
    gclear = 1'b0;

    // Table walk on gclk[0]
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_mode = VEC[i][8:6];
      cfg_dsrc = VEC[i][5:4];
      xor_in   = VEC[i][3];
      pt_data  = VEC[i][2];
      pin_in   = VEC[i][1];
      edge0();
      chk(VEC[i][0], tag_of(VEC[i][8:6], VEC[i][5:4]), $sformatf("vector %0d", i));
    end

    // R7: clock source selection, q is 1 here
    @(negedge clk);
    cfg_mode = 3'd0; cfg_dsrc = 2'd0; pt_data = 1'b0; pin_in = 1'b0;
    cfg_csrc = 2'd1; xor_in = 1'b0;
    edge0(); edge0();
    chk(1'b1, "R7", "gclk0 ignored when gclk1 selected");
    @(negedge clk);
    pulse_g1();
    chk(1'b0, "R7", "gclk1 edge captures");
    @(negedge clk);
    cfg_csrc = 2'd2; xor_in = 1'b1;
    pulse_g1();
    chk(1'b0, "R7", "gclk1 ignored when gclk2 selected");
    pulse_g2();
    chk(1'b1, "R7", "gclk2 edge captures");
    @(negedge clk);
    cfg_csrc = 2'd3; xor_in = 1'b0;
    edge0();
    chk(1'b1, "R7", "gclk0 ignored when pt_clk selected");
    @(negedge clk);
    pulse_pt();
    chk(1'b0, "R7", "pt_clk edge captures");

    // R8: clock enable
    @(negedge clk);
    cfg_csrc = 2'd0; cfg_ce_en = 1'b1; pt_ce = 1'b0; xor_in = 1'b1;
    edge0();
    chk(1'b0, "R8", "enable low blocks D capture");
    @(negedge clk);
    cfg_mode = 3'd1;
    edge0();
    chk(1'b0, "R8", "enable low blocks T toggle");
    @(negedge clk);
    pt_ce = 1'b1;
    edge0();
    chk(1'b1, "R8", "enable high lets T toggle");
    @(negedge clk);
    cfg_mode = 3'd0; cfg_csrc = 2'd3; pt_ce = 1'b0; xor_in = 1'b0;
    pulse_pt();
    chk(1'b0, "R8", "enable ignored with pt_clk");
    @(negedge clk);
    cfg_csrc = 2'd0; cfg_ce_en = 1'b0; xor_in = 1'b1;
    edge0();
    chk(1'b1, "R8", "enable switched off lets edge through");

    // R6: latch on gclk1
    @(negedge clk);
    cfg_csrc = 2'd1; cfg_mode = 3'd4; cfg_dsrc = 2'd0; xor_in = 1'b0;
    #0.5 g1 = 1'b1;
    #0.5 chk(1'b0, "R6", "latch transparent, data 0");
    xor_in = 1'b1;
    #0.5 chk(1'b1, "R6", "latch follows data to 1");
    g1 = 1'b0;
    #0.3 xor_in = 1'b0;
    #0.5 chk(1'b1, "R6", "latch holds while clock low");
    @(negedge clk);
    cfg_csrc = 2'd0; cfg_ce_en = 1'b1; pt_ce = 1'b0; xor_in = 1'b0;
    edge0();
    chk(1'b1, "R8", "enable low keeps latch closed");
    @(negedge clk);
    pt_ce = 1'b1;
    edge0();
    chk(1'b0, "R6", "latch opens with enable high");

    // Async clear and preset on a quiet clock
    @(negedge clk);
    cfg_csrc = 2'd1; cfg_ce_en = 1'b0; cfg_mode = 3'd0; xor_in = 1'b0;
    cfg_psrc = 1'b1; cfg_rsrc = 2'd2;
    #0.2 pt_preset = 1'b1;
    #0.2 chk(1'b1, "R10", "preset drives high");
    pt_preset = 1'b0;
    #0.2 pt_reset = 1'b1;
    #0.2 chk(1'b0, "R9", "pt_reset clears");
    pt_reset = 1'b0;
    #0.2 pt_preset = 1'b1;
    #0.2 pt_preset = 1'b0;
    cfg_rsrc = 2'd0;
    #0.2 pt_reset = 1'b1; gclear = 1'b1;
    #0.2 chk(1'b1, "R9", "no clear source selected");
    pt_reset = 1'b0; gclear = 1'b0;
    @(negedge clk);
    cfg_rsrc = 2'd1;
    #0.2 pt_reset = 1'b1;
    #0.2 chk(1'b1, "R9", "pt_reset unselected");
    pt_reset = 1'b0;
    #0.2 gclear = 1'b1;
    #0.2 chk(1'b0, "R9", "global clear selected");
    gclear = 1'b0;
    @(negedge clk);
    cfg_rsrc = 2'd3;
    #0.2 pt_preset = 1'b1;
    #0.2 pt_preset = 1'b0;
    #0.2 pt_reset = 1'b1;
    #0.2 chk(1'b0, "R9", "either source: pt_reset");
    pt_reset = 1'b0;
    #0.2 pt_preset = 1'b1;
    #0.2 pt_preset = 1'b0;
    #0.2 gclear = 1'b1;
    #0.2 chk(1'b0, "R9", "either source: gclear");
    gclear = 1'b0;
    @(negedge clk);
    cfg_psrc = 1'b0;
    #0.2 pt_preset = 1'b1;
    #0.2 chk(1'b0, "R10", "preset unselected");
    pt_preset = 1'b0;
    @(negedge clk);
    cfg_psrc = 1'b1; cfg_rsrc = 2'd2;
    #0.2 pt_preset = 1'b1; pt_reset = 1'b1;
    #0.2 chk(1'b0, "R11", "clear beats preset, flip-flop");
    pt_preset = 1'b0; pt_reset = 1'b0;
    @(negedge clk);
    cfg_mode = 3'd4;
    #0.2 pt_preset = 1'b1; pt_reset = 1'b1;
    #0.2 chk(1'b0, "R11", "clear beats preset, latch");
    pt_preset = 1'b0; pt_reset = 1'b0;

    @(negedge clk);
    finished = 1'b1;
    summary();
  end
endmodule